// File: doc/BRIEF.md
# Serial Memory Current-Address Counter

This block holds the 12-bit working address of a byte-wide serial memory. The bus sequencer loads it once per addressed transaction, from the four high address bits carried in the slave address and the eight-bit word address byte. It then pulses one strobe per data byte moved. Writes advance the address only inside a 32-byte page, so an over-long page write folds back onto the start of its own page. Reads advance across the whole 4 KiB space.

Between transactions the counter keeps its value, so a later read that sends no address starts at the right place. After a write it holds the exact location of the last byte written. After a read it holds the location one past the last byte read.

A flag reports whether the transaction began with an explicit load of the very top address. A neighbour uses this to tell an access to the top location from an access that only passes through it. The flag stays valid until the next transaction start.

Top module: `addr_seq_counter`

## Requirements
- R1: After reset `curAddr` is 0x000 and `startedAtTop` is 0.
- R2: A cycle with `loadStb` high makes `curAddr` equal `{hiAddr, wordByte}` (hiAddr in bits 11:8) in the next cycle, whatever the other strobes are.
- R3: The first `wrByteStb` after a load leaves `curAddr` unchanged, so the retained address is the one just written.
- R4: Each later `wrByteStb` adds one to bits 4:0 only, and bits 11:5 stay as they were. From low bits 0x1F the address returns to the page base, so a 33rd byte lands on the first byte's address.
- R5: A `rdByteStb` adds one to all 12 bits, and 0xFFF rolls over to 0x000.
- R6: With no strobe, and with `txnStartStb` alone, `curAddr` holds its value.
- R7: A load of 0xFFF sets `startedAtTop`. A load of any other value clears it.
- R8: `txnStartStb` without a load clears `startedAtTop`. Reaching 0xFFF by incrementing never sets it.
- R9: Strobes have the priority load over write over read. A cycle with both write and read strobes acts as a write only.
- R10: When `loadStb` and `txnStartStb` are high together, `startedAtTop` follows the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txnStartStb | input | 1 | A new bus transaction begins |
| loadStb | input | 1 | Load the address from hiAddr and wordByte |
| hiAddr | input | 4 | Address bits 11:8 from the slave address |
| wordByte | input | 8 | Address bits 7:0 from the word address byte |
| wrByteStb | input | 1 | One data byte was written |
| rdByteStb | input | 1 | One data byte was read |
| curAddr | output | 12 | Current address |
| startedAtTop | output | 1 | The transaction was loaded at 0xFFF |

## Verification
The hardest case to reach is the 33rd byte of a page write. It must fold back onto the first byte's address, and that only shows because the first byte after a load does not advance the counter. The stimulus loads a page base and streams 33 write strobes, and the expected address is checked after each one. It also walks a read from 0xFFE through 0xFFF to 0x000, to show that the top-address flag stays low when the top is reached by counting. Separate cycles raise several strobes at once to check the priority order.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

  // Per-cycle command from the control half to the datapath half.
  typedef struct packed {
    logic load;    // take a new address from the port fields
    logic wrAdv;   // step inside the current page
    logic rdAdv;   // step across the full space
    logic clrTop;  // drop the started-at-top flag
  } addrCmd_t;

endpackage

// File: rtl/addr_seq_ctrl.sv
module addr_seq_ctrl
  import addr_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txnStartStb,
  input  logic     loadStb,
  input  logic     wrByteStb,
  input  logic     rdByteStb,
  output addrCmd_t cmd
);

  // High from a load until the first written byte consumes the loaded address.
  logic firstWrPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstWrPending <= 1'b0;
    end else if (loadStb) begin
      firstWrPending <= 1'b1;
    end else if (wrByteStb) begin
      firstWrPending <= 1'b0;
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.load   = loadStb;
    cmd.wrAdv  = wrByteStb && !loadStb && !firstWrPending;
    cmd.rdAdv  = rdByteStb && !loadStb && !wrByteStb;
    cmd.clrTop = txnStartStb && !loadStb;
  end

endmodule

// File: rtl/addr_seq_dp.sv
module addr_seq_dp
  import addr_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrCmd_t          cmd,
  input  logic [ADDR_W-9:0] hiAddr,
  input  logic [7:0]        wordByte,
  output logic [ADDR_W-1:0] curAddr,
  output logic              startedAtTop
);

  logic [ADDR_W-1:0] loadVal;
  logic [ADDR_W-1:0] seqNext;
  logic [ADDR_W-1:0] pageNext;

  assign loadVal = {hiAddr, wordByte};
  assign seqNext = curAddr + 1'b1;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flatPage
      assign pageNext = seqNext;
    end else begin : g_splitPage
      logic [PAGE_W-1:0] lowNext;
      assign lowNext  = curAddr[PAGE_W-1:0] + 1'b1;
      assign pageNext = {curAddr[ADDR_W-1:PAGE_W], lowNext};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (cmd.load) begin
      curAddr <= loadVal;
    end else if (cmd.wrAdv) begin
      curAddr <= pageNext;
    end else if (cmd.rdAdv) begin
      curAddr <= seqNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startedAtTop <= 1'b0;
    end else if (cmd.load) begin
      startedAtTop <= (loadVal == {ADDR_W{1'b1}});
    end else if (cmd.clrTop) begin
      startedAtTop <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_seq_counter.sv
module addr_seq_counter
  import addr_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStartStb,
  input  logic              loadStb,
  input  logic [HI_W-1:0]   hiAddr,
  input  logic [7:0]        wordByte,
  input  logic              wrByteStb,
  input  logic              rdByteStb,
  output logic [ADDR_W-1:0] curAddr,
  output logic              startedAtTop
);

  addrCmd_t cmd;

  addr_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txnStartStb (txnStartStb),
    .loadStb     (loadStb),
    .wrByteStb   (wrByteStb),
    .rdByteStb   (rdByteStb),
    .cmd         (cmd)
  );

  addr_seq_dp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .hiAddr       (hiAddr),
    .wordByte     (wordByte),
    .curAddr      (curAddr),
    .startedAtTop (startedAtTop)
  );

endmodule

// File: rtl/addr_seq_counter_chk.sv
module addr_seq_counter_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  localparam int HI_W  = ADDR_W - 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txnStartStb,
  input logic              loadStb,
  input logic [HI_W-1:0]   hiAddr,
  input logic [7:0]        wordByte,
  input logic              wrByteStb,
  input logic              rdByteStb,
  input logic [ADDR_W-1:0] curAddr,
  input logic              startedAtTop
);

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> curAddr == $past({hiAddr, wordByte}));

  assert_first_write_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadStb) && wrByteStb && !loadStb) |=> curAddr == $past(curAddr));

  assert_page_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrByteStb && !loadStb) |=> curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W]));

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdByteStb && !wrByteStb && !loadStb) |=> curAddr == ADDR_W'($past(curAddr) + 1));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !wrByteStb && !rdByteStb) |=> $stable(curAddr));

  assert_top_only_by_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startedAtTop) |-> $past(loadStb));

  assert_start_clears_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txnStartStb && !loadStb) |=> !startedAtTop);

endmodule

bind addr_seq_counter addr_seq_counter_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/addr_seq_counter_bench.sv
module addr_seq_counter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnStartStb = 1'b0;
  logic        loadStb = 1'b0;
  logic [3:0]  hiAddr = '0;
  logic [7:0]  wordByte = '0;
  logic        wrByteStb = 1'b0;
  logic        rdByteStb = 1'b0;
  logic [11:0] curAddr;
  logic        startedAtTop;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  logic [11:0] mAddr = '0;
  logic        mTop = 1'b0;
  logic        mPend = 1'b0;

  logic [11:0] qAddr[$];
  logic        qTop[$];
  string       qTag[$];

  always #2.5 clk = ~clk;

  addr_seq_counter #(.ADDR_W(12), .PAGE_W(5)) u_addr_seq_counter (
    .clk(clk), .rstN(rstN), .txnStartStb(txnStartStb), .loadStb(loadStb),
    .hiAddr(hiAddr), .wordByte(wordByte), .wrByteStb(wrByteStb),
    .rdByteStb(rdByteStb), .curAddr(curAddr), .startedAtTop(startedAtTop)
  );

  // Driver: one cycle of strobes, then queue the expected outputs.
  task automatic step(input logic ld, input logic wr, input logic rd,
                      input logic tx, input logic [11:0] a, input string tag);
    @(negedge clk);
    loadStb = ld; wrByteStb = wr; rdByteStb = rd; txnStartStb = tx;
    hiAddr = a[11:8]; wordByte = a[7:0];
    if (ld) begin
      mAddr = a; mTop = (a == 12'hFFF); mPend = 1'b1;
    end else if (wr) begin
      if (mPend) mPend = 1'b0;
      else mAddr = {mAddr[11:5], mAddr[4:0] + 5'd1};
    end else if (rd) begin
      mAddr = mAddr + 12'd1;
    end
    if (tx && !ld) mTop = 1'b0;
    @(posedge clk);
    #1;
    loadStb = 1'b0; wrByteStb = 1'b0; rdByteStb = 1'b0; txnStartStb = 1'b0;
    qAddr.push_back(mAddr); qTop.push_back(mTop); qTag.push_back(tag);
  endtask

  // Monitor: compare at the falling edge after each driven cycle.
  always @(negedge clk) begin
    if (qAddr.size() > 0) begin
      logic [11:0] eA;
      logic        eT;
      string       t;
      eA = qAddr.pop_front(); eT = qTop.pop_front(); t = qTag.pop_front();
      checks++;
      if (curAddr !== eA || startedAtTop !== eT) begin
        failures++;
        $display("FAIL %s addr=%03h top=%b expected addr=%03h top=%b",
                 t, curAddr, startedAtTop, eA, eT);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (curAddr !== 12'h000 || startedAtTop !== 1'b0) begin
      failures++;
      $display("FAIL R1 addr=%03h top=%b expected addr=000 top=0", curAddr, startedAtTop);
    end

    step(1, 0, 0, 1, 12'h3A5, "R2 load");
    step(0, 1, 0, 0, 12'h000, "R3 first write");
    step(0, 1, 0, 0, 12'h000, "R4 second write");

    step(1, 0, 0, 1, 12'h1FE, "R2 load near page end");
    step(0, 1, 0, 0, 12'h000, "R3 first write");
    step(0, 1, 0, 0, 12'h000, "R4 to 1FF");
    step(0, 1, 0, 0, 12'h000, "R4 page wrap to 1E0");
    step(0, 0, 0, 0, 12'h000, "R6 idle hold");
    step(0, 0, 0, 1, 12'h000, "R6 start hold");
    step(0, 0, 1, 0, 12'h000, "R5 read after write");

    step(1, 0, 0, 1, 12'h240, "R2 page base");
    for (int i = 0; i < 33; i++) step(0, 1, 0, 0, 12'h000, "R4 long page write");

    step(1, 0, 0, 1, 12'hFFE, "R7 load FFE");
    step(0, 0, 1, 0, 12'h000, "R8 read to FFF");
    step(0, 0, 1, 0, 12'h000, "R5 roll over");
    step(0, 0, 1, 0, 12'h000, "R5 read 001");

    step(1, 0, 0, 1, 12'hFFF, "R7 load top");
    step(0, 0, 0, 0, 12'h000, "R7 flag persists");
    step(0, 0, 0, 1, 12'h000, "R8 start clears");
    step(1, 0, 0, 0, 12'hFFF, "R7 load top again");
    step(1, 0, 0, 0, 12'h123, "R7 other load clears");
    step(1, 0, 0, 1, 12'hFFF, "R10 load with start");

    step(1, 1, 1, 0, 12'h010, "R9 load wins");
    step(0, 1, 1, 0, 12'h000, "R9 write over read first");
    step(0, 1, 1, 0, 12'h000, "R9 write over read step");

    step(1, 0, 0, 1, 12'h7F0, "R2 sequential base");
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 12'h000, "R5 sequential");

    wait (qAddr.size() == 0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule